// File: doc/BRIEF.md
# Heartbeat Boundary and Timing Feature Extractor

This block sits behind a QRS detector. It receives the detector's filtered sample stream and its one-sample detection strobe. For every accepted beat it works out how far back the QRS complex began and how far forward it ended. It also measures how many samples separate the beat from the previous one and turns that spacing into a heart rate in beats per minute. Those values are packed into one record, and the record is queued for a host to read.

Boundaries are found from the slope of the stream. A circular history buffer keeps recent samples so the engine can walk backward from the detection point. It then walks forward as new samples arrive. The first position whose absolute slope falls below a programmable threshold marks the boundary. When no such position lies within the programmable window, the window edge is taken and a flag is set. The heart rate is 21600 divided by the beat spacing, which is the per-minute count at a 360 Hz sample rate. A restoring divider computes it one quotient bit per clock.

Top module: `ecg_beat_features`

## Requirements
- R1: While `rst_n` is low at a clock edge, the queue, the history buffer (all entries zero), the interval counter and the state are cleared. After that edge `rec_valid` and `overflow` read 0.
- R2: The slope at position p is |x[p] - x[p-1]|, computed on 12-bit signed samples. For a detection on sample d, the onset distance k is the smallest k in 1..B for which the slope at d-k is strictly less than `slope_thr`. B is `back_win`, and a value of 0 counts as 1. k goes into record bits [28:23].
- R3: If no onset position qualifies within B, k = B and the onset-missing flag (bit 43) is 1. Otherwise that flag is 0.
- R4: The offset distance j is the smallest j in 1..F for which the slope at d+j is strictly less than `slope_thr`. F is `fwd_win`, and 0 counts as 1. If none qualifies, j = F and the offset-missing flag (bit 42) is 1. The width field, bits [22:16], holds k + j.
- R5: The interval field (bits [40:29]) holds the number of samples from the previous accepted detection to this one, and the interval-valid bit (bit 41) is 1. For the first accepted detection after reset, the interval is 0 and the valid bit is 0.
- R6: The interval saturates at 4095.
- R7: The rate field (bits [15:0]) holds floor(21600 / interval) when the interval-valid bit is 1, and 0 otherwise.
- R8: A detection strobe that arrives while an earlier beat is still being processed is ignored. It produces no record and does not restart the interval measurement.
- R9: Records leave the queue in arrival order. `rec_data` shows the oldest record whenever `rec_valid` is 1. A clock edge with `rd_en` high removes it. `rd_en` while the queue is empty has no effect.
- R10: A record that finds the queue full (`FIFO_DEPTH` entries) is discarded and `overflow` becomes 1. `overflow` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | A new filtered sample is present this cycle |
| sample_in | input | 12 | Filtered sample, two's complement |
| beat_det | input | 1 | Detection strobe, meaningful only with `sample_valid` |
| slope_thr | input | 12 | Absolute-slope threshold (unsigned) |
| back_win | input | 6 | Backward search window in samples (0 treated as 1) |
| fwd_win | input | 6 | Forward search window in samples (0 treated as 1) |
| rd_en | input | 1 | Remove the record at the head of the queue |
| rec_valid | output | 1 | Queue holds at least one record |
| rec_data | output | 44 | Record at the head of the queue |
| overflow | output | 1 | Sticky: a record was dropped on a full queue |

## Verification
The bench builds triangular beats whose ramps are steeper than the threshold and whose bases are flat. The expected onset and offset therefore sit at known places, and a design that used a non-strict comparison, took the slope at the wrong index, or lost one sample at either end reports a wrong distance or width. Windows shorter than the ramp force the edge-with-flag case, which catches a design that stops one step early or flags a boundary it did find. An extra strobe inside a beat checks that late detections are neither queued nor allowed to restart the interval. A long flat gap checks saturation of the interval and of the rate. Five beats with no reads check that the fifth record is dropped rather than overwriting the oldest, that `overflow` stays set, and that a read on an empty queue leaves nothing behind.

// File: rtl/ecg_feat_pkg.sv
// Package: shared widths, constants and the per-beat record layout.
// Assumes 12-bit signed samples and a 360 Hz sample rate for the rate constant.
package ecg_feat_pkg;
    parameter int SMP_W  = 12;              // sample width
    parameter int WIN_W  = 6;               // search window field width
    parameter int RR_W   = 12;              // beat interval width
    parameter int HR_W   = 16;              // rate width
    parameter int WID_W  = WIN_W + 1;       // width field holds k + j
    parameter int HR_NUM = 21600;           // 60 s * 360 samples/s

    // Packed record, MSB first: bit 43 down to bit 0.
    typedef struct packed {
        logic               err_on;      // onset not found inside window
        logic               err_off;     // offset not found inside window
        logic               rr_ok;       // interval is meaningful
        logic [RR_W-1:0]    rr;          // samples since previous beat
        logic [WIN_W-1:0]   onset_back;  // onset distance behind detection
        logic [WID_W-1:0]   width;       // onset-to-offset span
        logic [HR_W-1:0]    hr;          // beats per minute
    } beat_rec_t;

    parameter int REC_W = $bits(beat_rec_t);
endpackage

// File: rtl/ecg_hist_buf.sv
// Circular sample history with one write port and two combinational read ports.
// Assumes the caller manages the write address; reset clears every entry to zero.
module ecg_hist_buf #(
    parameter int DEPTH = 256,
    parameter int W     = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic signed [W-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr_a,
    input  logic [AW-1:0]       rd_addr_b,
    output logic signed [W-1:0] rd_a,
    output logic signed [W-1:0] rd_b
);
    logic signed [W-1:0] mem [DEPTH];

    // Store incoming samples; reset zeroes the whole history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read both neighbours needed for one slope evaluation.
    always_comb begin
        rd_a = mem[rd_addr_a];
        rd_b = mem[rd_addr_b];
    end
endmodule

// File: rtl/ecg_seq_div.sv
// Restoring divider: constant numerator over a variable denominator, one quotient bit per clock.
// Assumes start is a single-cycle pulse; done pulses NUM_W cycles later with quot valid.
module ecg_seq_div #(
    parameter int NUM_W     = 16,
    parameter int DEN_W     = 12,
    parameter int NUMERATOR = 21600,
    localparam int CW       = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    logic [DEN_W:0]   rem;
    logic [DEN_W:0]   trial;
    logic [NUM_W-1:0] q;
    logic [CW-1:0]    cnt;

    // Shift the next dividend bit into the partial remainder.
    always_comb trial = {rem[DEN_W-1:0], q[NUM_W-1]};

    // One restoring step per cycle until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            q    <= '0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem <= '0;
                q   <= NUM_W'(NUMERATOR);
                cnt <= CW'(NUM_W);
            end else if (cnt != '0) begin
                if (trial >= {1'b0, den}) begin
                    rem <= trial - {1'b0, den};
                    q   <= {q[NUM_W-2:0], 1'b1};
                end else begin
                    rem <= trial;
                    q   <= {q[NUM_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) done <= 1'b1;
            end
        end
    end

    assign quot = q;
endmodule

// File: rtl/ecg_rec_fifo.sv
// Show-ahead record queue with drop-on-full and a sticky overflow flag.
// Assumes DEPTH is a power of two.
module ecg_rec_fifo #(
    parameter int W     = 44,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         ovf
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          push_ok, pop_ok;

    // Qualify requests against the current fill level.
    always_comb begin
        push_ok = push && (cnt != (AW+1)'(DEPTH));
        pop_ok  = pop && (cnt != '0);
    end

    // Write accepted records into storage.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Advance pointers, track fill level and latch overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (!push_ok && pop_ok) cnt <= cnt - 1'b1;
            if (push && !push_ok) ovf <= 1'b1;
        end
    end

    assign dout      = mem[rp];
    assign not_empty = (cnt != '0);
endmodule

// File: rtl/ecg_beat_features.sv
// Per-beat feature extractor: windowed slope search for QRS onset and offset,
// beat interval counting, rate division and record queueing.
// Assumes beat_det is only meaningful with sample_valid, and that window and
// threshold inputs are held steady while a beat is in flight.
module ecg_beat_features
    import ecg_feat_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int HIST       = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [SMP_W-1:0] sample_in,
    input  logic             beat_det,
    input  logic [SMP_W-1:0] slope_thr,
    input  logic [WIN_W-1:0] back_win,
    input  logic [WIN_W-1:0] fwd_win,
    input  logic             rd_en,
    output logic             rec_valid,
    output logic [REC_W-1:0] rec_data,
    output logic             overflow
);
    localparam int HAW = $clog2(HIST);
    localparam logic [RR_W-1:0] RR_MAX = '1;

    typedef enum logic [2:0] {S_IDLE, S_BACK, S_FWD, S_DIV, S_PUSH} eng_st_t;

    eng_st_t            st;
    logic [HAW-1:0]     wr_ptr, d_idx, rd_addr_a, rd_addr_b;
    logic signed [SMP_W-1:0] smp_a, smp_b;
    logic [SMP_W:0]     slope_mag;
    logic               flat, avail, engine_busy, det_acc;
    logic [RR_W-1:0]    gap_cnt, gap_next, rr_l;
    logic               rr_ok_l, seen;
    logic [WIN_W-1:0]   bw_l, fw_l, k_cnt, j_cnt, kb_l, jf_l;
    logic               err_on_l, err_off_l;
    logic [HR_W-1:0]    hr_l, div_q;
    logic               div_start, div_done;
    logic               rec_push;
    beat_rec_t          push_rec;

    // Treat a zero window as a one-sample window.
    function automatic logic [WIN_W-1:0] win_fix(input logic [WIN_W-1:0] w);
        return (w == '0) ? WIN_W'(1) : w;
    endfunction

    // Accept a detection only while the engine is idle.
    always_comb begin
        engine_busy = (st != S_IDLE);
        det_acc     = sample_valid && beat_det && !engine_busy;
        gap_next    = (gap_cnt == RR_MAX) ? gap_cnt : gap_cnt + 1'b1;
    end

    // Write pointer into the history, one step per sample.
    always_ff @(posedge clk) begin
        if (!rst_n)            wr_ptr <= '0;
        else if (sample_valid) wr_ptr <= wr_ptr + 1'b1;
    end

    ecg_hist_buf #(.DEPTH(HIST), .W(SMP_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sample_valid),
        .wr_addr   (wr_ptr),
        .wr_data   (sample_in),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .rd_a      (smp_a),
        .rd_b      (smp_b)
    );

    // Choose the sample pair for the current search step.
    always_comb begin
        if (st == S_FWD) rd_addr_a = d_idx + HAW'(j_cnt);
        else             rd_addr_a = d_idx - HAW'(k_cnt);
        rd_addr_b = rd_addr_a - 1'b1;
    end

    // Absolute slope, threshold test and sample availability for the forward walk.
    always_comb begin
        logic signed [SMP_W:0] dlt;
        dlt       = {smp_a[SMP_W-1], smp_a} - {smp_b[SMP_W-1], smp_b};
        slope_mag = dlt[SMP_W] ? (SMP_W+1)'(-dlt) : (SMP_W+1)'(dlt);
        flat      = slope_mag < {1'b0, slope_thr};
        avail     = (wr_ptr - d_idx) > HAW'(j_cnt);
    end

    // Samples since the last accepted detection, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            gap_cnt <= '0;
        else if (det_acc)      gap_cnt <= '0;
        else if (sample_valid) gap_cnt <= gap_next;
    end

    assign div_start = (st == S_FWD) && avail && (flat || (j_cnt == fw_l));

    // Search, divide and push sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            d_idx     <= '0;
            rr_l      <= '0;
            rr_ok_l   <= 1'b0;
            seen      <= 1'b0;
            bw_l      <= WIN_W'(1);
            fw_l      <= WIN_W'(1);
            k_cnt     <= WIN_W'(1);
            j_cnt     <= WIN_W'(1);
            kb_l      <= '0;
            jf_l      <= '0;
            err_on_l  <= 1'b0;
            err_off_l <= 1'b0;
            hr_l      <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (det_acc) begin
                    d_idx   <= wr_ptr;
                    rr_l    <= seen ? gap_next : '0;
                    rr_ok_l <= seen;
                    seen    <= 1'b1;
                    bw_l    <= win_fix(back_win);
                    fw_l    <= win_fix(fwd_win);
                    k_cnt   <= WIN_W'(1);
                    st      <= S_BACK;
                end
                S_BACK: begin
                    if (flat || (k_cnt == bw_l)) begin
                        kb_l     <= k_cnt;
                        err_on_l <= !flat;
                        j_cnt    <= WIN_W'(1);
                        st       <= S_FWD;
                    end else begin
                        k_cnt <= k_cnt + 1'b1;
                    end
                end
                S_FWD: if (avail) begin
                    if (flat || (j_cnt == fw_l)) begin
                        jf_l      <= j_cnt;
                        err_off_l <= !flat;
                        st        <= S_DIV;
                    end else begin
                        j_cnt <= j_cnt + 1'b1;
                    end
                end
                S_DIV: if (div_done) begin
                    hr_l <= rr_ok_l ? div_q : '0;
                    st   <= S_PUSH;
                end
                S_PUSH:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    ecg_seq_div #(.NUM_W(HR_W), .DEN_W(RR_W), .NUMERATOR(HR_NUM)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .den   (rr_l),
        .done  (div_done),
        .quot  (div_q)
    );

    // Assemble the record from the latched landmarks and interval.
    always_comb begin
        rec_push            = (st == S_PUSH);
        push_rec.err_on     = err_on_l;
        push_rec.err_off    = err_off_l;
        push_rec.rr_ok      = rr_ok_l;
        push_rec.rr         = rr_l;
        push_rec.onset_back = kb_l;
        push_rec.width      = WID_W'(kb_l) + WID_W'(jf_l);
        push_rec.hr         = hr_l;
    end

    ecg_rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rec_push),
        .din       (push_rec),
        .pop       (rd_en),
        .dout      (rec_data),
        .not_empty (rec_valid),
        .ovf       (overflow)
    );
endmodule

// File: rtl/ecg_beat_features_chk.sv
// Checker for the feature extractor: temporal properties on ports and latched state.
// Assumes it is bound into ecg_beat_features, whose signal names it mirrors.
module ecg_beat_features_chk
    import ecg_feat_pkg::*;
#(
    parameter int HIST = 256,
    localparam int HAW = $clog2(HIST)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sample_valid,
    input logic           beat_det,
    input logic           engine_busy,
    input logic [HAW-1:0] d_idx,
    input logic           rec_push,
    input beat_rec_t      push_rec,
    input logic [WIN_W-1:0] bw_l,
    input logic [WIN_W-1:0] fw_l,
    input logic           rec_valid,
    input logic           overflow
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!rec_valid && !overflow));

    assert_onset_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_push && push_rec.err_on) |-> (push_rec.onset_back == bw_l));

    assert_width_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_push |-> ((push_rec.width <= (WID_W'(bw_l) + WID_W'(fw_l)))
                      && (push_rec.width > WID_W'(push_rec.onset_back))));

    assert_first_beat_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_push && !push_rec.rr_ok) |-> ((push_rec.rr == '0) && (push_rec.hr == '0)));

    assert_busy_det_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && sample_valid && beat_det) |=> $stable(d_idx));

    assert_push_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_push |=> rec_valid);

    assert_no_overflow_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind ecg_beat_features ecg_beat_features_chk #(.HIST(HIST)) u_chk (.*);

// File: tb/ecg_beat_features_tb.sv
// Directed bench: triangular beats with known boundaries, one task per scenario.
module ecg_beat_features_tb;
    import ecg_feat_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sample_valid = 1'b0;
    logic [SMP_W-1:0] sample_in = '0;
    logic             beat_det = 1'b0;
    logic [SMP_W-1:0] slope_thr = 12'd5;
    logic [WIN_W-1:0] back_win = 6'd8;
    logic [WIN_W-1:0] fwd_win = 6'd8;
    logic             rd_en = 1'b0;
    logic             rec_valid;
    logic [REC_W-1:0] rec_data;
    logic             overflow;

    ecg_beat_features u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
        .beat_det(beat_det), .slope_thr(slope_thr), .back_win(back_win), .fwd_win(fwd_win),
        .rd_en(rd_en), .rec_valid(rec_valid), .rec_data(rec_data), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int sig [0:16383];
    int nsmp = 0;
    int vec = 0;
    int bad = 0;
    int cyc = 0;
    int last_det = 0;
    bit have_prev = 1'b0;
    int pend_d[$];
    int pend_rr[$];
    bit pend_ok[$];

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog R1..: actual %0d cycles expected <= %0d", cyc, WATCHDOG);
            report();
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int samp(input int i);
        return (i < 0) ? 0 : sig[i];
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Expected record from the requirement definitions.
    function automatic logic [REC_W-1:0] model(input int d, input int rr, input bit ok);
        beat_rec_t r;
        int bw, fw, thr, k, j, rrs;
        bit fk, fj;
        bw = (back_win == 0) ? 1 : int'(back_win);
        fw = (fwd_win == 0) ? 1 : int'(fwd_win);
        thr = int'(slope_thr);
        fk = 0; k = bw;
        for (int i = 1; i <= bw; i++) begin
            if (!fk && iabs(samp(d-i) - samp(d-i-1)) < thr) begin fk = 1; k = i; end
        end
        fj = 0; j = fw;
        for (int i = 1; i <= fw; i++) begin
            if (!fj && iabs(samp(d+i) - samp(d+i-1)) < thr) begin fj = 1; j = i; end
        end
        rrs = ok ? ((rr > 4095) ? 4095 : rr) : 0;
        r.err_on     = !fk;
        r.err_off    = !fj;
        r.rr_ok      = ok;
        r.rr         = RR_W'(rrs);
        r.onset_back = WIN_W'(k);
        r.width      = WID_W'(k + j);
        r.hr         = ok ? HR_W'(21600 / rrs) : '0;
        return r;
    endfunction

    task automatic send(input int v, input bit det);
        @(negedge clk);
        sample_in = v[SMP_W-1:0];
        sample_valid = 1'b1;
        beat_det = det;
        sig[nsmp] = v;
        nsmp++;
        @(negedge clk);
        sample_valid = 1'b0;
        beat_det = 1'b0;
    endtask

    // Flat lead, triangle of half-width hw and step s, flat tail; strobe at apex.
    task automatic beat(input int lead, input int hw, input int s, input bit extra, input bit keep);
        for (int i = 0; i < lead; i++) send(0, 1'b0);
        for (int m = -hw; m <= hw; m++) begin
            if (m == 0) begin
                if (keep) begin
                    pend_d.push_back(nsmp);
                    pend_rr.push_back(have_prev ? nsmp - last_det : 0);
                    pend_ok.push_back(have_prev);
                end
                last_det = nsmp;
                have_prev = 1'b1;
            end
            send(s * (hw - iabs(m)), (m == 0) || (extra && m == 3));
        end
        for (int i = 0; i < 70; i++) send(0, 1'b0);
    endtask

    // Wait for the head record, compare it with the model, then remove it.
    task automatic pop_expect(input string req, output beat_rec_t got);
        logic [REC_W-1:0] exp;
        int n = 0;
        while (!rec_valid && n < 300) begin @(negedge clk); n++; end
        exp = model(pend_d.pop_front(), pend_rr.pop_front(), pend_ok.pop_front());
        got = rec_data;
        check(rec_valid && rec_data == exp, req, 64'(rec_data), 64'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(rec_valid == 1'b0, "R1 rec_valid after reset", 64'(rec_valid), 64'd0);
        check(overflow == 1'b0, "R1 overflow after reset", 64'(overflow), 64'd0);
    endtask

    task automatic t_first_beat();
        beat_rec_t g;
        back_win = 6'd8; fwd_win = 6'd8; slope_thr = 12'd5;
        beat(20, 4, 10, 1'b0, 1'b1);
        pop_expect("R2 R4 R5 R7 first record", g);
        check(g.onset_back == 6'd4, "R2 onset distance", 64'(g.onset_back), 64'd4);
        check(g.width == 7'd9 && !g.err_off, "R4 width", 64'(g.width), 64'd9);
        check(!g.rr_ok && g.rr == 0 && g.hr == 0, "R5 R7 first beat interval", 64'(g.rr), 64'd0);
    endtask

    task automatic t_rate();
        beat_rec_t g;
        beat(21, 4, 10, 1'b0, 1'b1);   // 5 + 70 + 21 + 4 = 100 samples after previous apex
        pop_expect("R5 R7 interval record", g);
        check(g.rr_ok && g.rr == 12'd100, "R5 interval", 64'(g.rr), 64'd100);
        check(g.hr == 16'd216, "R7 rate", 64'(g.hr), 64'd216);
    endtask

    task automatic t_window_edges();
        beat_rec_t g;
        back_win = 6'd3; fwd_win = 6'd3;
        beat(20, 6, 10, 1'b0, 1'b1);
        pop_expect("R3 R4 edge record", g);
        check(g.err_on && g.onset_back == 6'd3, "R3 onset edge", 64'(g.onset_back), 64'd3);
        check(g.err_off && g.width == 7'd6, "R4 offset edge", 64'(g.width), 64'd6);
        back_win = 6'd0; fwd_win = 6'd0;
        beat(20, 4, 10, 1'b0, 1'b1);
        pop_expect("R2 R4 zero window as one", g);
        back_win = 6'd8; fwd_win = 6'd8;
    endtask

    task automatic t_ignore_busy();
        beat_rec_t g;
        beat(20, 4, 10, 1'b1, 1'b1);
        pop_expect("R8 first of pair", g);
        repeat (20) @(negedge clk);
        check(rec_valid == 1'b0, "R8 no record for busy strobe", 64'(rec_valid), 64'd0);
        beat(20, 4, 10, 1'b0, 1'b1);
        pop_expect("R8 interval from accepted strobe", g);
    endtask

    task automatic t_saturate();
        beat_rec_t g;
        beat(4200, 4, 10, 1'b0, 1'b1);
        pop_expect("R6 R7 long gap record", g);
        check(g.rr == 12'd4095, "R6 saturated interval", 64'(g.rr), 64'd4095);
        check(g.hr == 16'd5, "R7 rate at saturation", 64'(g.hr), 64'd5);
    endtask

    task automatic t_fifo_full();
        beat_rec_t g;
        for (int b = 0; b < 5; b++) beat(10 + b, 4, 10, 1'b0, b < 4);
        check(overflow == 1'b1, "R10 overflow set", 64'(overflow), 64'd1);
        for (int b = 0; b < 4; b++) pop_expect("R9 R10 order after drop", g);
        check(rec_valid == 1'b0, "R10 fifth record dropped", 64'(rec_valid), 64'd0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check(rec_valid == 1'b0, "R9 read on empty", 64'(rec_valid), 64'd0);
        check(overflow == 1'b1, "R10 overflow sticky", 64'(overflow), 64'd1);
        beat(25, 5, 9, 1'b0, 1'b1);
        pop_expect("R9 record after empty read", g);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_beat();
        t_rate();
        t_window_edges();
        t_ignore_busy();
        t_saturate();
        t_fifo_full();
        report();
    end
endmodule